// File: doc/BRIEF.md
# Scan-Port Debug Bus Bridge

This block turns a four-wire boundary-scan port into requests on a small debug bus. A sixteen-state test access port controller, clocked by the scan clock, walks the instruction and data scan paths. A five-bit instruction register chooses which data register sits between the serial input and the serial output. The main data register is a 40-bit access word. When the host completes a data scan with the access instruction selected, the bridge presents the word's address, data and operation to a debug module. The module's reply is then parked, so that the next access scan carries it back out.

The request side is valid/ready. Once `req_valid` rises, `req_addr`, `req_data` and `req_op` hold steady until the cycle in which `req_ready` is high. After that handshake, `rsp_ready` stays high until the module answers with `rsp_valid`. A `rsp_valid` pulse while `rsp_ready` is low is ignored. Only one request can be outstanding. An access update that arrives during that time is discarded, and it sets a sticky error that the host can see and clear.

The whole block runs in the scan clock domain. A 32-bit identification register, a 32-bit bridge control register and a 1-bit bypass register complete the data paths.

Top module: `dbgx_scan_bridge`

## Requirements
- R1: Five scan clocks with `tms` high bring the controller to its reset state from any state, including mid-shift. In that state the instruction becomes the identify code 5'h01, and `req_valid` and `rsp_ready` read 0.
- R2: The instruction register is 5 bits, shifted least significant bit first. Capture loads 5'b00001, which is the first thing shifted out. The new code takes effect on Update-IR.
- R3: Code 5'h01 selects a 32-bit identification register. It is loaded with the `IDCODE_VAL` parameter on Capture-DR and shifted out LSB first.
- R4: Any code other than 5'h01, 5'h10 and 5'h11 selects a 1-bit bypass stage that captures 0. A data scan therefore returns 0 followed by the input delayed by one bit.
- R5: Code 5'h11 selects the 40-bit access word, shifted LSB first. The operation is in bits [1:0], the data in [33:2] and the address in [39:34]. Operation 2'b01 is a read, 2'b10 is a write, and 2'b00 and 2'b11 do nothing.
- R6: If no request is outstanding, Update-DR of an access word with a read or write operation raises `req_valid` with that word's fields. The request stays valid and unchanged until `req_ready` is sampled high.
- R7: An access word with operation 2'b00 or 2'b11 issues no request.
- R8: After the handshake, `rsp_ready` is high until `rsp_valid`. Capture-DR of the access word then loads {last issued address, last response data, status}, where status 2'b00 means success.
- R9: An access update with a read or write while a request is outstanding is dropped and sets a sticky error. Capture status is 2'b11 while a request is outstanding or the sticky error is set.
- R10: Code 5'h10 selects a 32-bit control register. It captures the status from R9 in bits [1:0], with zeros above. An Update-DR with bit 16 set clears the sticky error.
- R11: Both scan branches accept the Exit1, Pause, Exit2 path. From Exit2 a scan may go to Update or resume shifting without losing bits.
- R12: Entering the reset state clears the sticky error and abandons any outstanding request. The last address and last data are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock, clocks all state |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Scan mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the active shift path |
| req_valid | output | 1 | Debug bus request valid |
| req_ready | input | 1 | Debug module accepts the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request write data |
| req_op | output | 2 | Request operation, 01 read, 10 write |
| rsp_valid | input | 1 | Response valid from the debug module |
| rsp_ready | output | 1 | Bridge awaits a response |
| rsp_data | input | DATA_W | Response data |

## Verification
A controller in the wrong state shows up on the next scan as shifted-out bits that are misaligned, or as an update that lands on the wrong register. The capture of 5'b00001 and the known identification word expose this within one scan. A wrong busy or sticky flag shows as a wrong status in bits [1:0] on the following access or control scan. It also shows as a request that appears, vanishes, or changes fields before `req_ready`, which is visible in the very next clock. Stale response data or a stale address shows in the next access capture.

// File: rtl/dbgx_scan_pkg.sv
package dbgx_scan_pkg;

  typedef enum logic [3:0] {
    TAP_RESET   = 4'd0,
    TAP_IDLE    = 4'd1,
    TAP_SEL_DR  = 4'd2,
    TAP_CAP_DR  = 4'd3,
    TAP_SH_DR   = 4'd4,
    TAP_EX1_DR  = 4'd5,
    TAP_PAU_DR  = 4'd6,
    TAP_EX2_DR  = 4'd7,
    TAP_UPD_DR  = 4'd8,
    TAP_SEL_IR  = 4'd9,
    TAP_CAP_IR  = 4'd10,
    TAP_SH_IR   = 4'd11,
    TAP_EX1_IR  = 4'd12,
    TAP_PAU_IR  = 4'd13,
    TAP_EX2_IR  = 4'd14,
    TAP_UPD_IR  = 4'd15
  } tap_state_e;

  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;

  localparam logic [1:0] ST_OK   = 2'b00;
  localparam logic [1:0] ST_BUSY = 2'b11;

endpackage

// File: rtl/dbgx_tap_fsm.sv
module dbgx_tap_fsm
  import dbgx_scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;
  logic [2:0] ones_cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      TAP_RESET:  nxt = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: nxt = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  nxt = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: nxt = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: nxt = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: nxt = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: nxt = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  nxt = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: nxt = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: nxt = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: nxt = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: nxt = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    nxt = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TAP_RESET;
    else         state <= nxt;
  end

  // run length of consecutive high mode-select samples, saturating at 5
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           ones_cnt <= 3'd0;
    else if (!tms)         ones_cnt <= 3'd0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R1: five high samples always land in the reset state
  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (state == TAP_RESET));

  // R11: from Exit2 a low select returns to shifting
  a_r11_exit2_resume: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TAP_EX2_DR && !tms) |=> (state == TAP_SH_DR));

endmodule

// File: rtl/dbgx_ir_unit.sv
module dbgx_ir_unit #(
  parameter int unsigned IR_W = 5,
  parameter logic [IR_W-1:0] RESET_CODE = 5'h01
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            in_reset,
  input  logic            cap_en,
  input  logic            shift_en,
  input  logic            upd_en,
  input  logic            tdi,
  output logic            sr_lsb,
  output logic [IR_W-1:0] code
);

  localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-1){1'b0}}, 1'b1};

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr   <= CAP_VAL;
      code <= RESET_CODE;
    end else begin
      if (cap_en)        sr <= CAP_VAL;
      else if (shift_en) sr <= {tdi, sr[IR_W-1:1]};
      if (in_reset)      code <= RESET_CODE;
      else if (upd_en)   code <= sr;
    end
  end

  assign sr_lsb = sr[0];

  // R2: capture pattern is present right after Capture-IR
  a_r2_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (sr == CAP_VAL));

  // R1: the reset state forces the identify code
  a_r1_ir_reset_code: assert property (@(posedge tck) disable iff (!trst_n)
    in_reset |=> (code == RESET_CODE));

  // R2: the active code only moves on an update or reset
  a_r2_code_stable: assert property (@(posedge tck) disable iff (!trst_n)
    (!upd_en && !in_reset) |=> $stable(code));

endmodule

// File: rtl/dbgx_dmi_unit.sv
module dbgx_dmi_unit
  import dbgx_scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              in_reset,
  input  logic              cap_en,
  input  logic              shift_en,
  input  logic              upd_en,
  input  logic              tdi,
  input  logic              sticky_clr,
  output logic              sr_lsb,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        req_op,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        status
);

  localparam int unsigned SCAN_W = ADDR_W + DATA_W + 2;
  localparam int unsigned D_LO   = 2;
  localparam int unsigned D_HI   = DATA_W + 1;
  localparam int unsigned A_LO   = DATA_W + 2;

  logic [SCAN_W-1:0] sr;
  logic              wait_q;
  logic              sticky;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic [1:0]        op_in;
  logic              is_req;
  logic              busy;

  assign op_in  = sr[1:0];
  assign is_req = (op_in == OP_RD) || (op_in == OP_WR);
  assign busy   = req_valid || wait_q;
  assign status = (busy || sticky) ? ST_BUSY : ST_OK;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      req_valid <= 1'b0;
      wait_q    <= 1'b0;
      sticky    <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
      req_op    <= OP_NONE;
      last_addr <= '0;
      last_data <= '0;
    end else if (in_reset) begin
      req_valid <= 1'b0;
      wait_q    <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        wait_q    <= 1'b1;
      end
      if (wait_q && rsp_valid) begin
        wait_q    <= 1'b0;
        last_data <= rsp_data;
      end
      if (sticky_clr) sticky <= 1'b0;
      if (upd_en && is_req) begin
        if (busy) begin
          sticky <= 1'b1;
        end else begin
          req_valid <= 1'b1;
          req_addr  <= sr[SCAN_W-1:A_LO];
          req_data  <= sr[D_HI:D_LO];
          req_op    <= op_in;
          last_addr <= sr[SCAN_W-1:A_LO];
        end
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sr <= '0;
    else if (cap_en)   sr <= {last_addr, last_data, status};
    else if (shift_en) sr <= {tdi, sr[SCAN_W-1:1]};
  end

  assign sr_lsb    = sr[0];
  assign rsp_ready = wait_q;

  // R6: an unaccepted request holds and keeps its fields
  a_r6_req_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (req_valid && !req_ready && !in_reset) |=>
      (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_op)));

  // R5: only read or write operations ever reach the bus
  a_r5_op_legal: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |-> (req_op == OP_RD || req_op == OP_WR));

  // R7: an inert operation raises no request
  a_r7_inert_op: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_en && !is_req && !req_valid) |=> !req_valid);

  // R8: request and response phases never overlap
  a_r8_one_phase: assert property (@(posedge tck) disable iff (!trst_n)
    req_valid |-> !rsp_ready);

  // R9: an update while busy is dropped and flagged
  a_r9_drop_sticky: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_en && is_req && busy && !in_reset) |=> (sticky && $stable(req_addr)));

  // R12: the reset state abandons the outstanding transfer
  a_r12_reset_clear: assert property (@(posedge tck) disable iff (!trst_n)
    in_reset |=> (!req_valid && !rsp_ready && status == ST_OK));

endmodule

// File: rtl/dbgx_scan_bridge.sv
module dbgx_scan_bridge
  import dbgx_scan_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IR_W       = 5,
  parameter logic [IR_W-1:0] IR_IDENT  = 5'h01,
  parameter logic [IR_W-1:0] IR_CTRL   = 5'h10,
  parameter logic [IR_W-1:0] IR_ACCESS = 5'h11,
  parameter logic [31:0] IDCODE_VAL = 32'h0C0D_E5A3,
  parameter int unsigned CLR_BIT    = 16
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [1:0]        req_op,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data
);

  localparam int unsigned AUX_W = 32;

  tap_state_e      st;
  logic [IR_W-1:0] ir_code;
  logic            ir_lsb;
  logic            dmi_lsb;
  logic [1:0]      dmi_status;
  logic            in_reset;
  logic            cap_dr, sh_dr, upd_dr;
  logic            sel_acc, sel_id, sel_ctl, sel_aux;
  logic [AUX_W-1:0] aux_sr;
  logic            byp_q;
  logic            sticky_clr;

  dbgx_tap_fsm u_tap (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (st)
  );

  assign in_reset = (st == TAP_RESET);
  assign cap_dr   = (st == TAP_CAP_DR);
  assign sh_dr    = (st == TAP_SH_DR);
  assign upd_dr   = (st == TAP_UPD_DR);

  dbgx_ir_unit #(
    .IR_W       (IR_W),
    .RESET_CODE (IR_IDENT)
  ) u_ir (
    .tck      (tck),
    .trst_n   (trst_n),
    .in_reset (in_reset),
    .cap_en   (st == TAP_CAP_IR),
    .shift_en (st == TAP_SH_IR),
    .upd_en   (st == TAP_UPD_IR),
    .tdi      (tdi),
    .sr_lsb   (ir_lsb),
    .code     (ir_code)
  );

  assign sel_acc = (ir_code == IR_ACCESS);
  assign sel_id  = (ir_code == IR_IDENT);
  assign sel_ctl = (ir_code == IR_CTRL);
  assign sel_aux = sel_id || sel_ctl;

  assign sticky_clr = upd_dr && sel_ctl && aux_sr[CLR_BIT];

  dbgx_dmi_unit #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dmi (
    .tck        (tck),
    .trst_n     (trst_n),
    .in_reset   (in_reset),
    .cap_en     (cap_dr && sel_acc),
    .shift_en   (sh_dr && sel_acc),
    .upd_en     (upd_dr && sel_acc),
    .tdi        (tdi),
    .sticky_clr (sticky_clr),
    .sr_lsb     (dmi_lsb),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .status     (dmi_status)
  );

  // shared 32-bit path for identification and control
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      aux_sr <= '0;
    end else if (cap_dr && sel_aux) begin
      aux_sr <= sel_id ? IDCODE_VAL : {{(AUX_W-2){1'b0}}, dmi_status};
    end else if (sh_dr && sel_aux) begin
      aux_sr <= {tdi, aux_sr[AUX_W-1:1]};
    end
  end

  // bypass stage for every other code
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      byp_q <= 1'b0;
    else if (cap_dr)  byp_q <= 1'b0;
    else if (sh_dr)   byp_q <= tdi;
  end

  always_comb begin
    tdo = 1'b0;
    if (st == TAP_SH_IR)  tdo = ir_lsb;
    else if (sh_dr) begin
      if (sel_acc)        tdo = dmi_lsb;
      else if (sel_aux)   tdo = aux_sr[0];
      else                tdo = byp_q;
    end
  end

  // R3: identification capture loads the fixed word
  a_r3_ident_capture: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && sel_id) |=> (aux_sr == IDCODE_VAL));

  // R10: a control update with the clear bit leaves no sticky error once idle
  a_r10_sticky_clear: assert property (@(posedge tck) disable iff (!trst_n)
    (sticky_clr && !req_valid && !rsp_ready) |=> (dmi_status == ST_OK));

  // R4: bypass captures zero
  a_r4_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
    cap_dr |=> !byp_q);

endmodule

// File: tb/dbgx_scan_bridge_tb.sv
`timescale 1ns/1ps
module dbgx_scan_bridge_tb;

  localparam logic [31:0] IDV = 32'h0C0D_E5A3;

  logic        tck = 1'b0;
  logic        trst_n, tms, tdi, tdo;
  logic        req_valid, req_ready, rsp_valid, rsp_ready;
  logic [5:0]  req_addr;
  logic [31:0] req_data, rsp_data;
  logic [1:0]  req_op;

  always #2.5 tck = ~tck;

  dbgx_scan_bridge u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_op(req_op), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural model of the bridge's transfer state
  bit          m_rv, m_wait, m_sticky;
  logic [5:0]  m_addr, m_last_addr;
  logic [31:0] m_data, m_last_data;
  logic [1:0]  m_op;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m; tdi = d; o = tdo;
    @(posedge tck);
    #1;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic tap_reset();
    logic o;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    m_rv = 0; m_wait = 0; m_sticky = 0;
  endtask

  task automatic scan_ir(input logic [4:0] v, input bit pause, output logic [4:0] out);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, v[i], o);
      out[i] = o;
    end
    if (pause) begin
      step(0, 0, o); step(0, 0, o); step(1, 0, o); step(1, 0, o);
    end else begin
      step(1, 0, o);
    end
    step(0, 0, o);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] v, input bit split, output logic [63:0] out);
    logic o;
    out = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      bit brk;
      brk = split && (i == n/2 - 1);
      step((i == n-1) || brk, v[i], o);
      out[i] = o;
      if (brk) begin
        step(0, 0, o); step(1, 0, o); step(0, 0, o);
      end
    end
    step(1, 0, o);
    step(0, 0, o);
  endtask

  function automatic logic [63:0] acc_word(input logic [5:0] a, input logic [31:0] d, input logic [1:0] op);
    return {24'd0, a, d, op};
  endfunction

  function automatic logic [63:0] cap_word();
    return acc_word(m_last_addr, m_last_data, (m_rv || m_wait || m_sticky) ? 2'b11 : 2'b00);
  endfunction

  // access scan against the model: capture first, then update
  task automatic acc_scan(input string tag, input logic [5:0] a, input logic [31:0] d,
                          input logic [1:0] op, input bit split);
    logic [63:0] exp, got;
    exp = cap_word();
    scan_dr(40, acc_word(a, d, op), split, got);
    chk(tag, got, exp);
    if (op == 2'b01 || op == 2'b10) begin
      if (m_rv || m_wait) m_sticky = 1;
      else begin
        m_rv = 1; m_addr = a; m_data = d; m_op = op; m_last_addr = a;
      end
    end
  endtask

  task automatic check_bus(input string tag);
    chk({tag, " req_valid"}, req_valid, m_rv);
    chk({tag, " rsp_ready"}, rsp_ready, m_wait);
    if (m_rv) chk({tag, " req fields"}, {req_addr, req_data, req_op}, {m_addr, m_data, m_op});
  endtask

  task automatic accept();
    @(negedge tck); req_ready = 1;
    @(posedge tck); #1; req_ready = 0;
    if (m_rv) begin m_rv = 0; m_wait = 1; end
  endtask

  task automatic respond(input logic [31:0] d);
    @(negedge tck); rsp_valid = 1; rsp_data = d;
    @(posedge tck); #1; rsp_valid = 0;
    if (m_wait) begin m_wait = 0; m_last_data = d; end
  endtask

  // every clock: an unaccepted request must keep its fields (R6)
  logic        p_rv, p_rdy;
  logic [39:0] p_fields;
  always @(negedge tck) begin
    if (trst_n && p_rv && !p_rdy && !done && req_valid)
      chk("R6 per-clock hold", {req_addr, req_data, req_op}, p_fields);
    p_rv = req_valid; p_rdy = req_ready; p_fields = {req_addr, req_data, req_op};
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0]  ir_out;
    logic [63:0] got;
    logic        o;
    trst_n = 0; tms = 1; tdi = 0; req_ready = 0; rsp_valid = 0; rsp_data = '0;
    m_rv = 0; m_wait = 0; m_sticky = 0; m_last_addr = '0; m_last_data = '0;
    m_addr = '0; m_data = '0; m_op = '0;
    repeat (3) @(negedge tck);
    trst_n = 1;
    idle(1);

    // R1: reset state
    chk("R1 reset req_valid", req_valid, 0);
    chk("R1 reset rsp_ready", rsp_ready, 0);
    // R3: default instruction reads identification
    scan_dr(32, 64'hFFFF_FFFF, 0, got);
    chk("R3 ident after reset", got, {32'd0, IDV});

    // R2: instruction capture pattern, select access
    scan_ir(5'h11, 0, ir_out);
    chk("R2 ir capture", ir_out, 5'b00001);

    // R5 R6: write request, held under back-pressure
    acc_scan("R5 first access capture", 6'h10, 32'h0000_0001, 2'b10, 0);
    check_bus("R6 write issued");
    idle(3);
    check_bus("R6 write held");
    accept();
    check_bus("R8 after accept");
    idle(2);
    check_bus("R8 awaiting response");
    respond(32'hAAAA_5555);
    check_bus("R8 after response");

    // R11: read scan through the pause path
    acc_scan("R11 split access scan", 6'h11, 32'h0, 2'b01, 1);
    check_bus("R11 read issued");
    accept();
    respond(32'h1234_5678);
    // R8 R7: no-op scan carries the response, issues nothing
    acc_scan("R8 read data returned", 6'h00, 32'h0, 2'b00, 0);
    check_bus("R7 nop no request");
    acc_scan("R7 op 11 capture", 6'h2A, 32'hDEAD_BEEF, 2'b11, 0);
    check_bus("R7 op 11 no request");

    // R9: busy drop and sticky status
    acc_scan("R9 read before busy", 6'h05, 32'h0, 2'b01, 0);
    acc_scan("R9 busy capture status", 6'h06, 32'h5, 2'b10, 0);
    check_bus("R9 dropped update");
    accept();
    respond(32'h0BAD_F00D);
    acc_scan("R9 sticky after idle", 6'h00, 32'h0, 2'b00, 0);

    // R10: control register clears sticky
    scan_ir(5'h10, 1, ir_out);
    chk("R11 ir pause capture", ir_out, 5'b00001);
    scan_dr(32, 64'h0001_0000, 0, got);
    chk("R10 control capture busy", got, 64'd3);
    m_sticky = 0;
    scan_dr(32, 64'h0, 0, got);
    chk("R10 control capture clear", got, 64'd0);
    scan_ir(5'h11, 0, ir_out);
    acc_scan("R10 access status clear", 6'h00, 32'h0, 2'b00, 0);

    // R4: bypass
    scan_ir(5'h07, 0, ir_out);
    scan_dr(8, 64'hB2, 0, got);
    chk("R4 bypass delay", got, {56'd0, 8'hB2 << 1} & 64'hFF);

    // R12: reset abandons transfer and sticky
    scan_ir(5'h11, 0, ir_out);
    acc_scan("R12 write before reset", 6'h21, 32'hCAFE_0001, 2'b10, 0);
    acc_scan("R12 busy drop", 6'h22, 32'h0, 2'b01, 0);
    check_bus("R12 outstanding");
    tap_reset();
    check_bus("R12 after reset");
    scan_dr(32, 64'h0, 0, got);
    chk("R1 ident code after reset", got, {32'd0, IDV});
    scan_ir(5'h11, 0, ir_out);
    acc_scan("R12 status clear kept addr", 6'h00, 32'h0, 2'b00, 0);

    // R1: reset from the middle of a data shift
    step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    tap_reset();
    scan_dr(32, 64'h0, 0, got);
    chk("R1 reset from shift", got, {32'd0, IDV});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule